// File: doc/BRIEF.md
# Serial Clock Prescaler

This block derives the serial bit clock for a serial peripheral engine from the parent clock. Both the transmit path and the receive path use one 16-bit scale word. The word holds two fields. The first is a coarse prescale field that multiplies the ratio by its value plus one. The second is a small power-of-two code. Together they give divide ratios from 1 to 1024. A separate code bypasses division altogether.

The block produces a registered serial clock level with a 50 percent duty cycle. It also produces a one-cycle period strobe that the frame engine uses to step its shift registers. An enable input starts and stops the clock. While the enable is low, the clock rests at a selectable idle level, and the scale word and idle level are captured only in that state. A running clock therefore never sees a change of setting part way through a period. Choosing the parent clock, and picking the nearest ratio, are left to the surrounding system.

Top module: `sck_prescaler`

## Requirements
- R1: The prescale field sits in bits 12:8 of `scale_cfg` and the divider code sits in bits 2:0. Bits 15:13 and 7:3 have no effect on the output.
- R2: Divider codes 0, 1, 2, 3 and 4 give a ratio of 2, 4, 8, 16 and 32 parent cycles times (prescale + 1). So 0x0000 gives 2, 0x0001 gives 4 and 0x0004 gives 32.
- R3: Divider code 7 bypasses division whatever the prescale field holds. `tick_o` is then high in every enabled cycle and `sck_o` stays at the idle level.
- R4: Divider codes 5 and 6 give the same ratio as code 4.
- R5: A prescale value p multiplies the ratio by p + 1. The value 0x1F multiplies by 32, so 0x1F00 gives 64 and 0x1F04 gives 1024, the largest ratio.
- R6: Take a ratio N of 2 or more, with the enable sampled high at edge k. After edge k+j, `sck_o` equals the idle level XOR the parity of floor((j+1)/(N/2)). This gives N/2 cycles at each level. After edge k+j, `tick_o` is high exactly when (j+1) is a multiple of N, which is the edge where `sck_o` returns to idle.
- R7: At every edge where `sck_en` is low, `sck_o` takes the `sck_idle` level and `tick_o` goes low, even part way through a period. The next enable starts a fresh period.
- R8: The scale word and the idle level are captured only at edges where `sck_en` is low. Changes to them while the clock is enabled do not alter the running waveform.
- R9: During reset, `sck_o` follows `sck_idle` and `tick_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_en | input | 1 | Serial clock run enable |
| sck_idle | input | 1 | Level of the serial clock while stopped |
| scale_cfg | input | 16 | Scale word: prescale field in 12:8, divider code in 2:0 |
| sck_o | output | 1 | Divided serial clock level |
| tick_o | output | 1 | One-cycle strobe per serial clock period |

## Verification
The bench goes after the seams of the encoding. These are the bypass code with a nonzero prescale field, the unused codes 5 and 6, the 0x1F prescale at the top ratio of 1024, and a prescale of 2 that makes a ratio which is not a power of two. A decoder that added the prescale instead of multiplying would produce a wrong period, and so would one that let code 7 honour the prescale field. Junk in the unused bits of the word would shift the period if those bits leaked into the decode. A setting change while running, and a disable part way through a period, target a design that re-reads the live scale word or lets the clock finish its half period. Either mistake shows up as a wrong `sck_o` level in the cycle sampled.

// File: rtl/sck_prescaler_pkg.sv
package sck_prescaler_pkg;

    // Field geometry of the scale word
    localparam int PRE_W      = 5;   // coarse prescale field width
    localparam int CODE_W     = 3;   // power-of-two code width
    localparam int PRE_LSB    = 8;
    localparam int CODE_LSB   = 0;
    localparam int CFG_W      = 16;
    localparam int POW_MAX    = 4;   // largest code that divides
    localparam int BYPASS_SEL = 7;   // code that passes the clock through

    // Half period = (pre+1) << pow, largest (2**PRE_W) << POW_MAX
    localparam int HALF_W = PRE_W + 1 + POW_MAX;

    typedef struct packed {
        logic              bypass;
        logic [HALF_W-1:0] half;
    } sck_setting_t;

    function automatic sck_setting_t decode_scale(
        input logic [PRE_W-1:0]  pre,
        input logic [CODE_W-1:0] code
    );
        sck_setting_t s;
        logic [CODE_W-1:0] pow;
        pow      = (code > CODE_W'(POW_MAX)) ? CODE_W'(POW_MAX) : code;
        s.bypass = (code == CODE_W'(BYPASS_SEL));
        s.half   = (HALF_W'(pre) + HALF_W'(1)) << pow;
        return s;
    endfunction

endpackage

// File: rtl/sck_cfg_latch.sv
module sck_cfg_latch
    import sck_prescaler_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              idle_in,
    input  logic [PRE_W-1:0]  pre_in,
    input  logic [CODE_W-1:0] code_in,
    output sck_setting_t      setting_q,
    output logic              idle_q
);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            setting_q <= decode_scale(pre_in, code_in);
            idle_q    <= idle_in;
        end
    end

    // R8: captured setting frozen while running
    assert_hold_cfg_R8: assert property (@(posedge clk) disable iff (rst)
        en |=> ($stable(setting_q) && $stable(idle_q)));

endmodule

// File: rtl/sck_div_core.sv
module sck_div_core
    import sck_prescaler_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         idle_in,
    input  logic         idle_q,
    input  sck_setting_t setting,
    output logic         sck_o,
    output logic         tick_o
);

    logic [HALF_W-1:0] cnt_q;
    logic              phase_q;
    logic              wrap;

    assign wrap = (cnt_q == (setting.half - HALF_W'(1)));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
            sck_o   <= idle_in;
            tick_o  <= 1'b0;
        end else if (setting.bypass) begin
            cnt_q   <= '0;
            tick_o  <= 1'b1;
        end else if (wrap) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
            sck_o   <= ~sck_o;
            tick_o  <= phase_q;
        end else begin
            cnt_q   <= cnt_q + HALF_W'(1);
            tick_o  <= 1'b0;
        end
    end

    assert_idle_off_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> ((sck_o == $past(idle_in)) && !tick_o));

    assert_tick_at_idle_R6: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> (sck_o == idle_q));

    assert_toggle_on_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (en && !setting.bypass && !wrap) |=> $stable(sck_o));

    assert_bypass_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (en && setting.bypass) |=> (tick_o && $stable(sck_o)));

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (en && !setting.bypass) |-> (cnt_q < setting.half));

endmodule

// File: rtl/sck_prescaler.sv
module sck_prescaler
    import sck_prescaler_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sck_en,
    input  logic             sck_idle,
    input  logic [CFG_W-1:0] scale_cfg,
    output logic             sck_o,
    output logic             tick_o
);

    sck_setting_t setting_q;
    logic         idle_q;
    logic         cfg_unused;

    // R1: only the two fields reach the decoder
    assign cfg_unused = ^{scale_cfg[CFG_W-1:PRE_LSB+PRE_W],
                          scale_cfg[PRE_LSB-1:CODE_LSB+CODE_W]};

    sck_cfg_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .en        (sck_en),
        .idle_in   (sck_idle),
        .pre_in    (scale_cfg[PRE_LSB +: PRE_W]),
        .code_in   (scale_cfg[CODE_LSB +: CODE_W]),
        .setting_q (setting_q),
        .idle_q    (idle_q)
    );

    sck_div_core u_core (
        .clk     (clk),
        .rst     (rst),
        .en      (sck_en),
        .idle_in (sck_idle),
        .idle_q  (idle_q),
        .setting (setting_q),
        .sck_o   (sck_o),
        .tick_o  (tick_o)
    );

    // R9: output held at the idle level under reset
    assert_reset_idle_R9: assert property (@(posedge clk)
        rst |=> (sck_o == $past(sck_idle)) && !tick_o);

endmodule

// File: tb/tb_sck_prescaler.sv
module tb_sck_prescaler;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck_en = 1'b0;
    logic        sck_idle = 1'b0;
    logic [15:0] scale_cfg = 16'h0000;
    logic        sck_o;
    logic        tick_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    sck_prescaler dut (
        .clk       (clk),
        .rst       (rst),
        .sck_en    (sck_en),
        .sck_idle  (sck_idle),
        .scale_cfg (scale_cfg),
        .sck_o     (sck_o),
        .tick_o    (tick_o)
    );

    // {idle, scale word, expected ratio}
    localparam logic [32:0] VECS [0:14] = '{
        {1'b0, 16'h0000, 16'd2},    // R2
        {1'b0, 16'h0001, 16'd4},    // R2
        {1'b1, 16'h0002, 16'd8},    // R2
        {1'b0, 16'h0003, 16'd16},   // R2
        {1'b1, 16'h0004, 16'd32},   // R2
        {1'b0, 16'h0007, 16'd1},    // R3
        {1'b1, 16'h1F07, 16'd1},    // R3 prescale ignored
        {1'b0, 16'h0005, 16'd32},   // R4
        {1'b1, 16'h0006, 16'd32},   // R4
        {1'b0, 16'h1F00, 16'd64},   // R5
        {1'b1, 16'h1F01, 16'd128},  // R5
        {1'b0, 16'h1F04, 16'd1024}, // R5 top ratio
        {1'b0, 16'h0200, 16'd6},    // R5 prescale of 2
        {1'b1, 16'h0201, 16'd12},   // R5
        {1'b0, 16'hE0F9, 16'd4}     // R1 junk in unused bits
    };

    function automatic logic exp_sck(int j, int n, logic idle);
        if (n == 1) return idle;
        return idle ^ ((((j + 1) / (n / 2)) % 2) == 1);
    endfunction

    function automatic logic exp_tick(int j, int n);
        return ((j + 1) % n) == 0;
    endfunction

    task automatic chk(input logic got, input logic exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic arm(input logic [15:0] cfg, input logic idle);
        @(negedge clk);
        sck_en    = 1'b0;
        scale_cfg = cfg;
        sck_idle  = idle;
        repeat (2) @(negedge clk);
        sck_en = 1'b1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R9: reset state with both idle levels
        sck_idle = 1'b1;
        repeat (3) @(negedge clk);
        chk(sck_o, 1'b1, "R9 reset sck idle high");
        chk(tick_o, 1'b0, "R9 reset tick");
        sck_idle = 1'b0;
        @(negedge clk);
        chk(sck_o, 1'b0, "R9 reset sck idle low");
        rst = 1'b0;

        // Table walk
        for (int v = 0; v < 15; v++) begin
            logic        idle;
            logic [15:0] cfg;
            int          n;
            idle = VECS[v][32];
            cfg  = VECS[v][31:16];
            n    = int'(VECS[v][15:0]);
            arm(cfg, idle);
            for (int j = 0; j < 2 * n + 2; j++) begin
                @(negedge clk);
                chk(sck_o, exp_sck(j, n, idle),
                    $sformatf("vec%0d sck j=%0d ratio=%0d", v, j, n));
                chk(tick_o, exp_tick(j, n),
                    $sformatf("vec%0d tick j=%0d ratio=%0d", v, j, n));
            end
        end

        // R8: setting and idle changes while running are ignored
        arm(16'h0000, 1'b0);
        for (int j = 0; j < 12; j++) begin
            @(negedge clk);
            chk(sck_o, exp_sck(j, 2, 1'b0), $sformatf("R8 sck j=%0d", j));
            chk(tick_o, exp_tick(j, 2), $sformatf("R8 tick j=%0d", j));
            if (j == 3) begin
                scale_cfg = 16'h1F04;
                sck_idle  = 1'b1;
            end
        end

        // R7: disable part way through a period, clock parks at idle at once
        arm(16'h0003, 1'b0);
        for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            chk(sck_o, exp_sck(j, 16, 1'b0), $sformatf("R7 run sck j=%0d", j));
        end
        chk(sck_o, 1'b1, "R7 high before stop");
        sck_en   = 1'b0;
        sck_idle = 1'b0;
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            chk(sck_o, 1'b0, "R7 parked sck");
            chk(tick_o, 1'b0, "R7 parked tick");
        end
        // R7: restart gives a fresh period
        sck_en = 1'b1;
        for (int j = 0; j < 20; j++) begin
            @(negedge clk);
            chk(sck_o, exp_sck(j, 16, 1'b0), $sformatf("R7 restart sck j=%0d", j));
            chk(tick_o, exp_tick(j, 16), $sformatf("R7 restart tick j=%0d", j));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule